// File: doc/BRIEF.md
# Capture/Compare Timer with Interrupt Vector

This block is a free-running timer built around a 16-bit counter and five capture/compare channels. The counter advances on ticks derived from one of three sources: an external clock pin, an auxiliary clock pin, or the system clock itself. A prescaler divides the selected source by 1, 2, 4 or 8. The counter can stand still, run continuously through the full 16-bit range, count up to the period held in channel 0, or count up to that period and back down to zero. The counter can be loaded at any time through a full-width write port, and its value is always visible.

Each channel has a capture mode and a compare mode. In capture mode, a chosen edge of a chosen input copies the counter into the channel register. In compare mode, the channel raises a one-cycle strobe when the counter takes on the register's value. Channel 0 has a dedicated interrupt line. Channels 1 to 4 and the counter overflow share a second line. A priority-encoded vector word names the most urgent of those five pending events. Its value is an even offset that software can add to its program counter to reach the matching handler.

All pins are plain control and status signals; no data stream crosses the block boundary, so there is no valid/ready handshake and no back-pressure. The external and auxiliary clock pins are sampled in the system clock domain.

Top module: `cc_timer`

## Requirements
- R1: `src_sel_i` picks the tick source: 0 = rising edges of `ext_clk_i`, 1 = rising edges of `aux_clk_i`, 2 or 3 = every system clock cycle. Edges are detected against the value sampled on the previous clock.
- R2: `div_sel_i` = 0, 1, 2, 3 divides the source by 1, 2, 4, 8, giving one counter step per N source pulses. A counter write restarts the divider, and the first step after a restart comes on the Nth pulse.
- R3: `mode_sel_i` = 0 holds the counter. A `cnt_wr_i` pulse loads `cnt_wdata_i` in any mode, takes priority over a step in the same cycle, and the new value appears one clock later.
- R4: In up mode (`mode_sel_i` = 1), a step taken while the counter is at or above the channel 0 register returns the counter to 0 and sets the overflow flag. Any other step adds one.
- R5: In continuous mode (`mode_sel_i` = 2), each step adds one. The step from 0xFFFF to 0 sets the overflow flag.
- R6: In up/down mode (`mode_sel_i` = 3), the counter rises to the channel 0 value, then falls one per step. The step that lands on 0 sets the overflow flag and turns the counter upward again.
- R7: A channel with `ch_capmode_i`[k] = 1 captures on its 2-bit edge field `ch_edge_i`[2k+1:2k]: 1 = rising, 2 = falling, 3 = both, 0 = never. A capture copies the counter value held at the clock edge where the input change is first sampled, and sets the channel flag on the same edge.
- R8: The capture input field `ch_insel_i`[2k+1:2k] selects the source: 0 = `ch_pin_i`[k], 1 = `aux_clk_i`, 2 or 3 = the software level `ch_sw_i`[k].
- R9: A channel with `ch_capmode_i`[k] = 0 compares. When a counter step makes the counter equal to `ccr_o`[k], the channel flag sets, and `cmp_eq_o`[k] is high for exactly that one cycle.
- R10: The channel 0 flag drives `irq0_o`. `irq0_clr_i` clears it. If a set and a clear fall on the same cycle, the set wins.
- R11: `vec_o` reads 2, 4, 6, 8 for pending channels 1–4 and 10 for overflow, or 0 when none is pending. The lowest channel number has the highest priority, and overflow is last. `irq_sh_o` is high exactly when `vec_o` is nonzero.
- R12: A `vec_rd_i` pulse clears only the flag that `vec_o` shows in that cycle. Every other pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel_i | input | 2 | Tick source select |
| div_sel_i | input | 2 | Prescaler divide select |
| mode_sel_i | input | 2 | Counter mode: 0 stop, 1 up, 2 continuous, 3 up/down |
| ext_clk_i | input | 1 | External tick pin |
| aux_clk_i | input | 1 | Auxiliary clock pin |
| cnt_wr_i | input | 1 | Counter load strobe |
| cnt_wdata_i | input | 16 | Counter load value |
| cnt_o | output | 16 | Counter value |
| ch_capmode_i | input | 5 | Per channel: 1 capture, 0 compare |
| ch_insel_i | input | 10 | Per channel 2-bit capture input select |
| ch_edge_i | input | 10 | Per channel 2-bit capture edge select |
| ch_pin_i | input | 5 | Per channel capture pin |
| ch_sw_i | input | 5 | Per channel software capture level |
| ccr_wr_i | input | 5 | Per channel register write strobe |
| ccr_wdata_i | input | 16 | Channel register write value |
| ccr_o | output | 80 | Channel registers, channel k at bits 16k+15:16k |
| cmp_eq_o | output | 5 | Per channel compare-equal strobe |
| irq0_clr_i | input | 1 | Clear for the channel 0 flag |
| irq0_o | output | 1 | Channel 0 interrupt request |
| irq_sh_o | output | 1 | Shared interrupt request |
| vec_rd_i | input | 1 | Vector read strobe, clears the reported flag |
| vec_o | output | 4 | Priority vector word |

## Verification
A counter step is taken on the same clock edge where its source pulse is sampled. A stimulus applied before clock edge n therefore appears on `cnt_o` after edge n. The flag and the compare strobe caused by that step appear after the same edge. A capture takes the value `cnt_o` held just before the edge where the input change is sampled, and the register and flag update on that edge. Clearing a flag with a vector read or with `irq0_clr_i` takes one edge.

The bench applies every stimulus half a period before an edge and counts edges explicitly. It samples results on the falling edge after the edge in which they are due, so each expected value refers to a known number of register stages.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  typedef enum logic [1:0] {
    MD_STOP = 2'd0,
    MD_UP   = 2'd1,
    MD_CONT = 2'd2,
    MD_UPDN = 2'd3
  } tmr_mode_e;

  localparam logic [1:0] SRC_EXT = 2'd0;
  localparam logic [1:0] SRC_AUX = 2'd1;

  localparam logic [1:0] CIN_PIN = 2'd0;
  localparam logic [1:0] CIN_AUX = 2'd1;
endpackage

// File: rtl/cc_tick_gen.sv
module cc_tick_gen #(
  parameter int DIV_W = 2,
  localparam int PRE_W = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             run,
  input  logic             restart,
  input  logic             ext_clk,
  input  logic             aux_clk,
  output logic             tick
);
  import cc_timer_pkg::*;

  logic             ext_q, aux_q;
  logic             pulse;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      aux_q <= 1'b0;
    end else begin
      ext_q <= ext_clk;
      aux_q <= aux_clk;
    end
  end

  always_comb begin
    case (src_sel)
      SRC_EXT: pulse = ext_clk & ~ext_q;
      SRC_AUX: pulse = aux_clk & ~aux_q;
      default: pulse = 1'b1;
    endcase
  end

  assign mask = ~({PRE_W{1'b1}} << div_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_q <= '0;
    else if (restart)        pre_q <= '0;
    else if (run && pulse)   pre_q <= pre_q + 1'b1;
  end

  assign tick = run & pulse & ((pre_q & mask) == mask);

  // R2: any divide above one forbids two steps in a row
  p_div_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel != '0 && !restart) |=> !tick);
endmodule

// File: rtl/cc_counter.sv
module cc_counter #(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  cc_timer_pkg::tmr_mode_e  mode,
  input  logic                     tick,
  input  logic                     wr,
  input  logic [W-1:0]             wdata,
  input  logic [W-1:0]             period,
  output logic [W-1:0]             cnt,
  output logic [W-1:0]             cnt_nxt,
  output logic                     step,
  output logic                     ovf_set
);
  import cc_timer_pkg::*;

  logic [W-1:0] cnt_q;
  logic         down_q, down_d;
  logic         wrap;

  always_comb begin
    cnt_nxt = cnt_q;
    down_d  = 1'b0;
    wrap    = 1'b0;
    case (mode)
      MD_CONT: begin
        cnt_nxt = cnt_q + 1'b1;
        wrap    = &cnt_q;
      end
      MD_UP: begin
        if (cnt_q >= period) begin
          cnt_nxt = '0;
          wrap    = 1'b1;
        end else begin
          cnt_nxt = cnt_q + 1'b1;
        end
      end
      MD_UPDN: begin
        if (down_q || cnt_q >= period) begin
          if (cnt_q <= W'(1)) begin
            cnt_nxt = '0;
            down_d  = 1'b0;
            wrap    = (cnt_q == W'(1));
          end else begin
            cnt_nxt = cnt_q - 1'b1;
            down_d  = 1'b1;
          end
        end else begin
          cnt_nxt = cnt_q + 1'b1;
        end
      end
      default: begin
        cnt_nxt = cnt_q;
        down_d  = down_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (wr) begin
      cnt_q  <= wdata;
      down_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= cnt_nxt;
      down_q <= down_d;
    end
  end

  assign cnt     = cnt_q;
  assign step    = tick & ~wr;
  assign ovf_set = step & wrap;

  // R3: a stopped counter without a write keeps its value
  p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_STOP && !wr) |=> $stable(cnt_q));
  // R3: a write lands one clock later
  p_write_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt_q == $past(wdata));
  // R4: a step at or above the period returns to zero
  p_up_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_UP && step && cnt_q >= period) |=> cnt_q == '0);
  // R6: a down-count overflow only comes from the value one
  p_updn_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && mode == MD_UPDN) |-> cnt_q == W'(1));
endmodule

// File: rtl/cc_channel.sv
module cc_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_mode,
  input  logic [1:0]   in_sel,
  input  logic [1:0]   edge_sel,
  input  logic         pin,
  input  logic         aux,
  input  logic         sw,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cnt_nxt,
  input  logic         step,
  output logic [W-1:0] ccr,
  output logic         evt,
  output logic         eq_stb
);
  import cc_timer_pkg::*;

  logic         src, src_q;
  logic         rise, fall, cap, cmp;
  logic [W-1:0] ccr_q;
  logic         eq_q;

  always_comb begin
    case (in_sel)
      CIN_PIN: src = pin;
      CIN_AUX: src = aux;
      default: src = sw;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src;
  end

  assign rise = src & ~src_q;
  assign fall = ~src & src_q;
  assign cap  = cap_mode & ((edge_sel[0] & rise) | (edge_sel[1] & fall));
  assign cmp  = ~cap_mode & step & (cnt_nxt == ccr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q <= '0;
      eq_q  <= 1'b0;
    end else begin
      eq_q <= cmp;
      if (wr)       ccr_q <= wdata;
      else if (cap) ccr_q <= cnt;
    end
  end

  assign ccr    = ccr_q;
  assign evt    = cap | cmp;
  assign eq_stb = eq_q;

  // R7: a capture holds the counter value seen at the capturing edge
  p_cap_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !wr) |=> ccr_q == $past(cnt));
  // R9: the strobe appears only while counter and register agree
  p_eq_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_q && !$past(wr)) |-> ccr_q == cnt);
endmodule

// File: rtl/cc_irq_vec.sv
module cc_irq_vec #(
  parameter int NCH = 5,
  localparam int VW = $clog2(2 * NCH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_set,
  input  logic           ovf_set,
  input  logic           irq0_clr,
  input  logic           vec_rd,
  output logic           irq0,
  output logic           irq_sh,
  output logic [VW-1:0]  vec
);
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] clr_ch;
  logic           ovf_q, clr_ovf, found;

  always_comb begin
    vec     = '0;
    clr_ch  = '0;
    clr_ovf = 1'b0;
    found   = 1'b0;
    clr_ch[0] = irq0_clr;
    for (int i = 1; i < NCH; i++) begin
      if (!found && flag_q[i]) begin
        found     = 1'b1;
        vec       = VW'(2 * i);
        clr_ch[i] = vec_rd;
      end
    end
    if (!found && ovf_q) begin
      vec     = VW'(2 * NCH);
      clr_ovf = vec_rd;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[k] <= 1'b0;
      else        flag_q[k] <= ch_set[k] | (flag_q[k] & ~clr_ch[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_set | (ovf_q & ~clr_ovf);
  end

  assign irq0   = flag_q[0];
  assign irq_sh = (|flag_q[NCH-1:1]) | ovf_q;

  // R11: the shared request and a nonzero vector go together
  p_vec_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sh == (vec != '0));
  // R10: a set on channel 0 is never lost to a clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ch_set[0] |=> irq0);
  // R12: reading the overflow code removes the overflow flag
  p_rd_ovf_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec == VW'(2 * NCH) && !ovf_set) |=> !ovf_q);
  // R12: reading channel 1 leaves the overflow flag as it was
  p_rd_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec == VW'(2) && ovf_q) |=> ovf_q);
endmodule

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int CNT_W = 16,
  parameter int NCH   = 5,
  localparam int VEC_W = $clog2(2 * NCH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           src_sel_i,
  input  logic [1:0]           div_sel_i,
  input  logic [1:0]           mode_sel_i,
  input  logic                 ext_clk_i,
  input  logic                 aux_clk_i,
  input  logic                 cnt_wr_i,
  input  logic [CNT_W-1:0]     cnt_wdata_i,
  output logic [CNT_W-1:0]     cnt_o,
  input  logic [NCH-1:0]       ch_capmode_i,
  input  logic [2*NCH-1:0]     ch_insel_i,
  input  logic [2*NCH-1:0]     ch_edge_i,
  input  logic [NCH-1:0]       ch_pin_i,
  input  logic [NCH-1:0]       ch_sw_i,
  input  logic [NCH-1:0]       ccr_wr_i,
  input  logic [CNT_W-1:0]     ccr_wdata_i,
  output logic [CNT_W*NCH-1:0] ccr_o,
  output logic [NCH-1:0]       cmp_eq_o,
  input  logic                 irq0_clr_i,
  output logic                 irq0_o,
  output logic                 irq_sh_o,
  input  logic                 vec_rd_i,
  output logic [VEC_W-1:0]     vec_o
);
  import cc_timer_pkg::*;

  tmr_mode_e        mode;
  logic             tick, step, ovf_set;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [NCH-1:0]   ch_evt;

  assign mode = tmr_mode_e'(mode_sel_i);

  cc_tick_gen #(.DIV_W(2)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_sel (src_sel_i),
    .div_sel (div_sel_i),
    .run     (mode != MD_STOP),
    .restart (cnt_wr_i),
    .ext_clk (ext_clk_i),
    .aux_clk (aux_clk_i),
    .tick    (tick)
  );

  cc_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .tick    (tick),
    .wr      (cnt_wr_i),
    .wdata   (cnt_wdata_i),
    .period  (ccr_o[CNT_W-1:0]),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .step    (step),
    .ovf_set (ovf_set)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    cc_channel #(.W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_mode (ch_capmode_i[k]),
      .in_sel   (ch_insel_i[2*k +: 2]),
      .edge_sel (ch_edge_i[2*k +: 2]),
      .pin      (ch_pin_i[k]),
      .aux      (aux_clk_i),
      .sw       (ch_sw_i[k]),
      .wr       (ccr_wr_i[k]),
      .wdata    (ccr_wdata_i),
      .cnt      (cnt),
      .cnt_nxt  (cnt_nxt),
      .step     (step),
      .ccr      (ccr_o[CNT_W*k +: CNT_W]),
      .evt      (ch_evt[k]),
      .eq_stb   (cmp_eq_o[k])
    );
  end

  cc_irq_vec #(.NCH(NCH)) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_set   (ch_evt),
    .ovf_set  (ovf_set),
    .irq0_clr (irq0_clr_i),
    .vec_rd   (vec_rd_i),
    .irq0     (irq0_o),
    .irq_sh   (irq_sh_o),
    .vec      (vec_o)
  );

  assign cnt_o = cnt;

  // R5: continuous mode wraps from all ones to zero on a step
  p_cont_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_CONT && step && cnt == '1) |=> (cnt == '0 && irq_sh_o));
endmodule

// File: tb/tb_cc_timer.sv
module tb_cc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  src_sel = 2'd2, div_sel = 2'd0, mode_sel = 2'd0;
  logic        ext_clk = 1'b0, aux_clk = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic [15:0] cnt_o;
  logic [4:0]  capm = 5'b11110;
  logic [9:0]  insel = '0, edg = '0;
  logic [4:0]  pin = '0, sw = '0, ccr_wr = '0;
  logic [15:0] ccr_wdata = '0;
  logic [79:0] ccr_o;
  logic [4:0]  cmp_eq;
  logic        irq0_clr = 1'b0, irq0, irq_sh, vec_rd = 1'b0;
  logic [3:0]  vec;

  int errors = 0;
  int checks = 0;
  logic [15:0] c1, c2;

  always #2 clk = ~clk;

  cc_timer dut (
    .clk(clk), .rst_n(rst_n), .src_sel_i(src_sel), .div_sel_i(div_sel),
    .mode_sel_i(mode_sel), .ext_clk_i(ext_clk), .aux_clk_i(aux_clk),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata), .cnt_o(cnt_o),
    .ch_capmode_i(capm), .ch_insel_i(insel), .ch_edge_i(edg),
    .ch_pin_i(pin), .ch_sw_i(sw), .ccr_wr_i(ccr_wr), .ccr_wdata_i(ccr_wdata),
    .ccr_o(ccr_o), .cmp_eq_o(cmp_eq), .irq0_clr_i(irq0_clr), .irq0_o(irq0),
    .irq_sh_o(irq_sh), .vec_rd_i(vec_rd), .vec_o(vec)
  );

  typedef struct packed {
    logic [1:0]  md;
    logic [1:0]  dv;
    logic [15:0] per;
    logic [7:0]  ncyc;
    logic [15:0] exp;
    logic        ovf;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{2'd2, 2'd0, 16'd0, 8'd10, 16'd10, 1'b0},
    '{2'd2, 2'd2, 16'd0, 8'd10, 16'd2,  1'b0},
    '{2'd2, 2'd3, 16'd0, 8'd20, 16'd2,  1'b0},
    '{2'd2, 2'd1, 16'd0, 8'd7,  16'd3,  1'b0},
    '{2'd1, 2'd0, 16'd5, 8'd5,  16'd5,  1'b0},
    '{2'd1, 2'd0, 16'd5, 8'd6,  16'd0,  1'b1},
    '{2'd1, 2'd0, 16'd5, 8'd8,  16'd2,  1'b1},
    '{2'd1, 2'd1, 16'd3, 8'd9,  16'd0,  1'b1},
    '{2'd3, 2'd0, 16'd4, 8'd4,  16'd4,  1'b0},
    '{2'd3, 2'd0, 16'd4, 8'd6,  16'd2,  1'b0},
    '{2'd3, 2'd0, 16'd4, 8'd8,  16'd0,  1'b1},
    '{2'd3, 2'd0, 16'd4, 8'd9,  16'd1,  1'b1},
    '{2'd0, 2'd0, 16'd0, 8'd10, 16'd0,  1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // stop, load counter and channel 0, clear every flag
  task automatic prep(input logic [15:0] start, input logic [15:0] per);
    @(negedge clk);
    mode_sel = 2'd0; cnt_wr = 1'b1; cnt_wdata = start;
    ccr_wr = 5'b00001; ccr_wdata = per;
    @(negedge clk);
    cnt_wr = 1'b0; ccr_wr = '0; irq0_clr = 1'b1; vec_rd = 1'b1;
    repeat (6) @(negedge clk);
    irq0_clr = 1'b0; vec_rd = 1'b0;
  endtask

  task automatic rd_vec();
    vec_rd = 1'b1;
    @(negedge clk);
    vec_rd = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R3, R11)
    chk("R3 reset cnt", cnt_o, 0);
    chk("R11 reset vec", vec, 0);
    chk("R11 reset irq_sh", irq_sh, 0);
    chk("R10 reset irq0", irq0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of modes and divides (R2, R4, R5, R6, R3)
    for (int i = 0; i < NV; i++) begin
      prep(16'd0, TBL[i].per);
      div_sel = TBL[i].dv; mode_sel = TBL[i].md; src_sel = 2'd2;
      repeat (int'(TBL[i].ncyc)) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2/R4/R6 row %0d cnt", i), cnt_o, TBL[i].exp);
      chk($sformatf("R4/R5/R6 row %0d ovf vec", i), vec, TBL[i].ovf ? 10 : 0);
    end

    // R5: continuous wrap, then R12: read clears overflow
    prep(16'hFFFE, 16'd0);
    div_sel = 2'd0; mode_sel = 2'd2;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R5 wrap cnt", cnt_o, 0);
    chk("R5 wrap vec", vec, 10);
    mode_sel = 2'd0;
    rd_vec();
    chk("R12 ovf cleared", vec, 0);

    // R1: external pin ticks
    prep(16'd0, 16'd0);
    src_sel = 2'd0; mode_sel = 2'd2;
    repeat (5) @(negedge clk);
    chk("R1 ext idle", cnt_o, 0);
    for (int k = 0; k < 3; k++) begin
      ext_clk = 1'b1; @(negedge clk); ext_clk = 1'b0; repeat (2) @(negedge clk);
    end
    chk("R1 ext pulses", cnt_o, 3);
    // R1: auxiliary ticks
    src_sel = 2'd1;
    for (int k = 0; k < 2; k++) begin
      aux_clk = 1'b1; @(negedge clk); aux_clk = 1'b0; @(negedge clk);
    end
    chk("R1 aux pulses", cnt_o, 5);

    // R3: write while running wins over step
    src_sel = 2'd2;
    cnt_wr = 1'b1; cnt_wdata = 16'h1234;
    @(negedge clk);
    cnt_wr = 1'b0;
    chk("R3 write running", cnt_o, 16'h1234);

    // R7/R8: pin capture on channel 2, rising only
    prep(16'd0, 16'd0);
    mode_sel = 2'd2; src_sel = 2'd2;
    edg[5:4] = 2'd1; insel[5:4] = 2'd0;
    repeat (4) @(negedge clk);
    c1 = cnt_o; pin[2] = 1'b1;
    @(negedge clk);
    chk("R7 pin rise ccr2", ccr_o[47:32], c1);
    chk("R7 flag vec", vec, 4);
    pin[2] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 fall ignored", ccr_o[47:32], c1);
    rd_vec();
    chk("R12 ch2 cleared", vec, 0);

    // R7/R8: software capture on channel 3, both edges
    edg[7:6] = 2'd3; insel[7:6] = 2'd2;
    repeat (2) @(negedge clk);
    c1 = cnt_o; sw[3] = 1'b1;
    @(negedge clk);
    chk("R8 sw rise ccr3", ccr_o[63:48], c1);
    repeat (2) @(negedge clk);
    c2 = cnt_o; sw[3] = 1'b0;
    @(negedge clk);
    chk("R7 sw fall ccr3", ccr_o[63:48], c2);

    // R8: aux capture on channel 4, falling only
    edg[9:8] = 2'd2; insel[9:8] = 2'd1;
    aux_clk = 1'b1;
    repeat (2) @(negedge clk);
    c1 = cnt_o; aux_clk = 1'b0;
    @(negedge clk);
    chk("R8 aux fall ccr4", ccr_o[79:64], c1);
    chk("R11 ch3 before ch4", vec, 6);

    // R11/R12: priority among pending channels
    edg[3:2] = 2'd1; insel[3:2] = 2'd2;
    @(negedge clk);
    sw[1] = 1'b1;
    @(negedge clk);
    chk("R11 ch1 first", vec, 2);
    rd_vec();
    chk("R12 ch3 remains", vec, 6);
    rd_vec();
    chk("R12 ch4 remains", vec, 8);
    rd_vec();
    chk("R11 none left", vec, 0);
    chk("R11 irq_sh low", irq_sh, 0);

    // R9: compare strobe on channel 1
    prep(16'd0, 16'd100);
    capm[1] = 1'b0;
    ccr_wr = 5'b00010; ccr_wdata = 16'd3;
    @(negedge clk);
    ccr_wr = '0; mode_sel = 2'd2; div_sel = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 cmp strobe", cmp_eq[1], 1);
    chk("R9 cmp flag", vec, 2);
    @(negedge clk);
    chk("R9 strobe one cycle", cmp_eq[1], 0);
    capm[1] = 1'b1;

    // R10: channel 0 interrupt and set-wins
    prep(16'd0, 16'd2);
    chk("R10 irq0 cleared", irq0, 0);
    mode_sel = 2'd1;
    @(posedge clk);
    @(negedge clk);
    irq0_clr = 1'b1;
    @(negedge clk);
    chk("R10 set wins", irq0, 1);
    @(negedge clk);
    irq0_clr = 1'b0;
    chk("R10 clear", irq0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule